// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches 32 general-purpose input pins and turns their activity into interrupt requests. Each pin is brought into the local clock domain through a short synchronizer chain. It can then be set to sense a level or an edge. The polarity is selectable per pin, and a separate per-pin control makes the pin fire on either transition whatever its type and polarity say. Per-pin enable and mask bits decide whether a pin takes part at all and whether it reaches the combined interrupt line. Software reads a raw status (every enabled event) and a masked status (what actually drives the interrupt). It acknowledges edge events by writing ones to an end-of-interrupt register.

Every writable register is 32 bits wide but is reached as two half-word locations. The lower location holds pins 15..0 and the location 4 bytes above it holds pins 31..16. In a write, bits 31..16 of the data are per-bit write enables for bits 15..0. This lets software change one pin's setting without a read-modify-write. A read returns the selected half in bits 15..0, with zeros above.

Edge events are latched until they are acknowledged. Level events are not latched: they follow the synchronized pin for as long as the condition holds.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration register, both status registers and `irqOut` read as zero.
- R2: Registers sit at these offsets: enable 0x10, mask 0x18, type 0x20, polarity 0x28, any-edge 0x30. A write to the offset updates pins 15..0 and a write to offset+4 updates pins 31..16. Data bit 16+i enables the write of bit i, and bits whose enable is 0 keep their value. A read returns the selected half in bits 15..0 and zero in bits 31..16.
- R3: A pin with type bit 0 and its any-edge bit 0 senses a level: active high when its polarity bit is 1 and active low when it is 0. Its raw status bit (0x58/0x5C) follows the synchronized pin and is not latched. A pin change shows after two clock edges.
- R4: A pin with type bit 1 and its any-edge bit 0 senses an edge: rising when its polarity bit is 1 and falling when it is 0. The event is latched in raw status, where it shows three clock edges after the pin change. The opposite edge sets nothing.
- R5: A pin whose any-edge bit is 1 latches an event on both rising and falling transitions, whatever its type and polarity bits hold.
- R6: A write at 0x60 (pins 15..0) or 0x64 (pins 31..16) clears the latched event of every pin whose data bit and enable bit are both 1. An edge detected in the same cycle wins over the clear. These locations read as zero.
- R7: A pin whose enable bit is 0 records no event. Clearing the enable bit drops a latched event by the next clock edge.
- R8: A mask bit of 1 removes the pin from the masked status (0x50/0x54) and from `irqOut`, while the raw status still records the event.
- R9: `irqOut` is high exactly when at least one masked status bit is set.
- R10: Writes to the status locations 0x50, 0x54, 0x58 and 0x5C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 32 | Asynchronous pin levels |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWr | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 32 | Write data: bits 31..16 enables, bits 15..0 values |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands in the very clock cycle in which a new edge of the same pin is detected. Reaching it means counting the two synchronizer stages and the edge-reference register between the pin and the latch. The bench raises the pin and then issues the end-of-interrupt write so that it is sampled on the third clock edge after the change. It then checks that the event survives. A long phase of sparse random pin toggles, mixed with random half-word writes to every location, follows. A behavioural model is compared against the read data and the interrupt line on every cycle during this phase.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int HALF_W  = 16;
  localparam int PIN_W   = 2 * HALF_W;
  localparam int ADDR_W  = 8;
  localparam int NCFG    = 5;

  // configuration register indices
  localparam int IDX_EN   = 0;
  localparam int IDX_MASK = 1;
  localparam int IDX_TYPE = 2;
  localparam int IDX_POL  = 3;
  localparam int IDX_ANY  = 4;

  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_EOI  = 8'h60;
  localparam logic [ADDR_W-1:0] HI_STEP  = 8'h04;

  typedef struct packed {
    logic [NCFG-1:0]   wrLo;
    logic [NCFG-1:0]   wrHi;
    logic              eoiLo;
    logic              eoiHi;
    logic [HALF_W-1:0] bits;
    logic [HALF_W-1:0] wen;
  } regStrobe_t;

  function automatic logic [ADDR_W-1:0] cfgOffset(int idx);
    case (idx)
      IDX_EN:   return 8'h10;
      IDX_MASK: return 8'h18;
      IDX_TYPE: return 8'h20;
      IDX_POL:  return 8'h28;
      default:  return 8'h30;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWr,
  input  logic [PIN_W-1:0]            regWdata,
  input  logic [NCFG-1:0][PIN_W-1:0]  cfgView,
  input  logic [PIN_W-1:0]            rawView,
  input  logic [PIN_W-1:0]            maskedView,
  output regStrobe_t                  strobe,
  output logic [PIN_W-1:0]            regRdata
);
  logic [NCFG-1:0] loHit;
  logic [NCFG-1:0] hiHit;

  for (genvar c = 0; c < NCFG; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO_OFF = cfgOffset(c);
    assign loHit[c] = (regAddr == LO_OFF);
    assign hiHit[c] = (regAddr == LO_OFF + HI_STEP);
  end

  // write strobes (R2, R6); status locations decode to nothing (R10)
  always_comb begin
    strobe.wrLo  = regWr ? loHit : '0;
    strobe.wrHi  = regWr ? hiHit : '0;
    strobe.eoiLo = regWr && (regAddr == OFF_EOI);
    strobe.eoiHi = regWr && (regAddr == OFF_EOI + HI_STEP);
    strobe.bits  = regWdata[HALF_W-1:0];
    strobe.wen   = regWdata[PIN_W-1:HALF_W];
  end

  logic [PIN_W-1:0] word;
  logic             upper;

  always_comb begin
    word  = '0;
    upper = 1'b0;
    for (int c = 0; c < NCFG; c++) begin
      if (loHit[c]) word = cfgView[c];
      if (hiHit[c]) begin
        word  = cfgView[c];
        upper = 1'b1;
      end
    end
    if (regAddr == OFF_STAT) word = maskedView;
    if (regAddr == OFF_STAT + HI_STEP) begin
      word  = maskedView;
      upper = 1'b1;
    end
    if (regAddr == OFF_RAW) word = rawView;
    if (regAddr == OFF_RAW + HI_STEP) begin
      word  = rawView;
      upper = 1'b1;
    end
    regRdata = {{HALF_W{1'b0}}, (upper ? word[PIN_W-1:HALF_W] : word[HALF_W-1:0])};
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [PIN_W-1:0]            pinIn,
  input  regStrobe_t                  strobe,
  output logic [NCFG-1:0][PIN_W-1:0]  cfgQ,
  output logic [PIN_W-1:0]            rawStatus,
  output logic [PIN_W-1:0]            maskedStatus,
  output logic                        irqOut
);
  // configuration registers with half-word write enables (R2)
  for (genvar c = 0; c < NCFG; c++) begin : g_cfg
    logic [PIN_W-1:0] regQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ <= '0;
      end else begin
        if (strobe.wrLo[c])
          regQ[HALF_W-1:0] <= (regQ[HALF_W-1:0] & ~strobe.wen) | (strobe.bits & strobe.wen);
        if (strobe.wrHi[c])
          regQ[PIN_W-1:HALF_W] <= (regQ[PIN_W-1:HALF_W] & ~strobe.wen) | (strobe.bits & strobe.wen);
      end
    end
    assign cfgQ[c] = regQ;
  end

  // input synchronizer and edge reference
  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncPipe;
  logic [PIN_W-1:0] syncIn;
  logic [PIN_W-1:0] prevIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe <= '0;
      prevIn   <= '0;
    end else begin
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], pinIn};
      prevIn   <= syncIn;
    end
  end
  assign syncIn = syncPipe[SYNC_STAGES-1];

  // acknowledge vector (R6)
  logic [PIN_W-1:0] eoiClr;
  assign eoiClr = {(strobe.eoiHi ? (strobe.bits & strobe.wen) : {HALF_W{1'b0}}),
                   (strobe.eoiLo ? (strobe.bits & strobe.wen) : {HALF_W{1'b0}})};

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    logic rise, fall, edgeHit, levelHit, latchQ;
    logic en, typ, pol, any;

    assign en   = cfgQ[IDX_EN][p];
    assign typ  = cfgQ[IDX_TYPE][p];
    assign pol  = cfgQ[IDX_POL][p];
    assign any  = cfgQ[IDX_ANY][p];
    assign rise = syncIn[p] & ~prevIn[p];
    assign fall = ~syncIn[p] & prevIn[p];

    always_comb begin
      if (any)      edgeHit = rise | fall;         // R5
      else if (typ) edgeHit = pol ? rise : fall;   // R4
      else          edgeHit = 1'b0;
      edgeHit = edgeHit & en;
    end

    // level sense, unlatched (R3)
    assign levelHit = en & ~any & ~typ & (syncIn[p] == pol);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           latchQ <= 1'b0;
      else if (!en)        latchQ <= 1'b0;   // R7
      else if (edgeHit)    latchQ <= 1'b1;   // new edge beats acknowledge (R6)
      else if (eoiClr[p])  latchQ <= 1'b0;
    end

    assign rawStatus[p] = latchQ | levelHit;
  end

  assign maskedStatus = rawStatus & ~cfgQ[IDX_MASK];   // R8
  assign irqOut       = |maskedStatus;                 // R9
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [PIN_W-1:0]  regWdata,
  output logic [PIN_W-1:0]  regRdata,
  output logic              irqOut
);
  regStrobe_t                 strobe;
  logic [NCFG-1:0][PIN_W-1:0] cfgQ;
  logic [PIN_W-1:0]           rawStatus;
  logic [PIN_W-1:0]           maskedStatus;

  gpio_irq_ctrl u_ctrl (
    .regAddr    (regAddr),
    .regWr      (regWr),
    .regWdata   (regWdata),
    .cfgView    (cfgQ),
    .rawView    (rawStatus),
    .maskedView (maskedStatus),
    .strobe     (strobe),
    .regRdata   (regRdata)
  );

  gpio_irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pinIn        (pinIn),
    .strobe       (strobe),
    .cfgQ         (cfgQ),
    .rawStatus    (rawStatus),
    .maskedStatus (maskedStatus),
    .irqOut       (irqOut)
  );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              irqOut,
  input logic [ADDR_W-1:0] regAddr,
  input logic [PIN_W-1:0]  regRdata,
  input logic [PIN_W-1:0]  enQ,
  input logic [PIN_W-1:0]  maskQ,
  input logic [PIN_W-1:0]  rawStatus,
  input logic [PIN_W-1:0]  maskedStatus
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[PIN_W-1:HALF_W] == '0);

  p_eoi_reads_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFF_EOI || regAddr == OFF_EOI + HI_STEP) |-> regRdata == '0);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus & ~enQ & ~$past(enQ)) == '0);

  p_masked_within_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    (maskedStatus & (maskQ | ~rawStatus)) == '0);

  p_irq_from_raw_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(rawStatus & ~maskQ));
endmodule

bind gpio_irq_detect gpio_irq_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .irqOut       (irqOut),
  .regAddr      (regAddr),
  .regRdata     (regRdata),
  .enQ          (cfgQ[0]),
  .maskQ        (cfgQ[1]),
  .rawStatus    (rawStatus),
  .maskedStatus (maskedStatus)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] pinIn = 32'h0000_0002;
  logic [7:0]  regAddr = 8'h00;
  logic        regWr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  always #2 clk = ~clk;   // 250 MHz

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  int nCmp = 0;
  int nBad = 0;
  int cyc  = 0;
  bit done = 1'b0;

  // ---------------- behavioural reference ----------------
  // cfg index: 0 enable, 1 mask, 2 type, 3 polarity, 4 any-edge
  logic [31:0] mCfg [5];
  logic [31:0] mS0 = '0, mS1 = '0, mPrev = '0, mLatch = '0;
  initial for (int c = 0; c < 5; c++) mCfg[c] = '0;

  function automatic logic [7:0] offOf(int c);
    case (c)
      0: return 8'h10; 1: return 8'h18; 2: return 8'h20; 3: return 8'h28; default: return 8'h30;
    endcase
  endfunction

  function automatic logic [31:0] mRaw();
    logic [31:0] lvl;
    lvl = mCfg[0] & ~mCfg[4] & ~mCfg[2] & ~(mS1 ^ mCfg[3]);
    return mLatch | lvl;
  endfunction

  function automatic logic [31:0] mMasked();
    return mRaw() & ~mCfg[1];
  endfunction

  function automatic logic mIrq();
    return |mMasked();
  endfunction

  function automatic logic [31:0] mRead(logic [7:0] a);
    logic [31:0] w;
    bit hi;
    w = '0; hi = 1'b0;
    for (int c = 0; c < 5; c++) begin
      if (a == offOf(c)) w = mCfg[c];
      if (a == offOf(c) + 8'h4) begin w = mCfg[c]; hi = 1'b1; end
    end
    if (a == 8'h50) w = mMasked();
    if (a == 8'h54) begin w = mMasked(); hi = 1'b1; end
    if (a == 8'h58) w = mRaw();
    if (a == 8'h5C) begin w = mRaw(); hi = 1'b1; end
    return hi ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
  endfunction

  always @(posedge clk) begin : mdl
    logic [31:0] sy, rise, fall, hit, clr, wv;
    if (!rstN) begin
      for (int c = 0; c < 5; c++) mCfg[c] = '0;
      mS0 = '0; mS1 = '0; mPrev = '0; mLatch = '0;
    end else begin
      sy = mS1;
      rise = sy & ~mPrev;
      fall = ~sy & mPrev;
      for (int p = 0; p < 32; p++) begin
        if (mCfg[4][p])      hit[p] = rise[p] | fall[p];
        else if (mCfg[2][p]) hit[p] = mCfg[3][p] ? rise[p] : fall[p];
        else                 hit[p] = 1'b0;
      end
      hit = hit & mCfg[0];
      wv  = regWdata[15:0] & regWdata[31:16];
      clr = '0;
      if (regWr && regAddr == 8'h60) clr[15:0]  = wv[15:0];
      if (regWr && regAddr == 8'h64) clr[31:16] = wv[15:0];
      mLatch = mCfg[0] & (hit | (mLatch & ~clr));
      for (int c = 0; c < 5; c++) begin
        for (int b = 0; b < 16; b++) begin
          if (regWr && regAddr == offOf(c) && regWdata[16+b]) mCfg[c][b] = regWdata[b];
          if (regWr && regAddr == offOf(c) + 8'h4 && regWdata[16+b]) mCfg[c][16+b] = regWdata[b];
        end
      end
      mPrev = sy;
      mS1 = mS0;
      mS0 = pinIn;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (!done) begin
      nCmp++;
      if (irqOut !== mIrq()) begin
        nBad++;
        $display("FAIL R9 irqOut cycle %0d got %0b exp %0b", cyc, irqOut, mIrq());
      end
      nCmp++;
      if (regRdata !== mRead(regAddr)) begin
        nBad++;
        $display("FAIL R2 read @%h cycle %0d got %h exp %h", regAddr, cyc, regRdata, mRead(regAddr));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      nBad++;
      $display("FAIL watchdog expired got cycle %0d exp below 60000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] bits, logic [15:0] wen);
    @(posedge clk); #1;
    regAddr = a; regWr = 1'b1; regWdata = {wen, bits};
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    chk(tag, regRdata, exp);
  endtask

  task automatic irqChk(logic exp, string tag);
    @(negedge clk);
    chk(tag, {31'h0, irqOut}, {31'h0, exp});
  endtask

  task automatic setPin(int p, logic v);
    @(posedge clk); #1;
    pinIn[p] = v;
    waitc(5);
  endtask

  function automatic logic [7:0] pickAddr(int k);
    if (k < 10) return offOf(k / 2) + ((k % 2) ? 8'h4 : 8'h0);
    case (k)
      10: return 8'h50; 11: return 8'h54; 12: return 8'h58;
      13: return 8'h5C; 14: return 8'h60; default: return 8'h64;
    endcase
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    waitc(3);
    @(posedge clk); #1 rstN = 1'b1;
    waitc(4);

    // R1 reset state
    rd(8'h10, 32'h0, "R1 enable after reset");
    rd(8'h2C, 32'h0, "R1 polarity high after reset");
    rd(8'h58, 32'h0, "R1 raw after reset");
    rd(8'h50, 32'h0, "R1 masked after reset");
    irqChk(1'b0, "R1 irqOut after reset");

    // R2 half-word enables; pins low + level-low mode raise raw (R3)
    wr(8'h10, 16'hA5A5, 16'h00FF);
    rd(8'h10, 32'h0000_00A5, "R2 enable low half partial write");
    wr(8'h14, 16'hFFFF, 16'h8001);
    rd(8'h14, 32'h0000_8001, "R2 enable high half partial write");
    rd(8'h58, 32'h0000_00A5, "R3 level-low raw low half");
    rd(8'h5C, 32'h0000_8001, "R3 level-low raw high half");
    irqChk(1'b1, "R9 irq from level-low pins");

    // all pins rising-edge, then enable all
    wr(8'h20, 16'hFFFF, 16'hFFFF);
    wr(8'h24, 16'hFFFF, 16'hFFFF);
    wr(8'h28, 16'hFFFF, 16'hFFFF);
    wr(8'h2C, 16'hFFFF, 16'hFFFF);
    wr(8'h10, 16'hFFFF, 16'hFFFF);
    wr(8'h14, 16'hFFFF, 16'hFFFF);
    rd(8'h58, 32'h0, "R4 no edges yet low half");
    rd(8'h5C, 32'h0, "R4 no edges yet high half");
    irqChk(1'b0, "R9 idle irq");

    // R3 level high on pin 0
    wr(8'h20, 16'h0000, 16'h0001);
    setPin(0, 1'b1);
    rd(8'h58, 32'h0000_0001, "R3 level-high active");
    irqChk(1'b1, "R9 irq from level-high");
    setPin(0, 1'b0);
    rd(8'h58, 32'h0, "R3 level not latched");

    // R4 rising on pin 4
    setPin(4, 1'b1);
    rd(8'h58, 32'h0000_0010, "R4 rising edge latched");
    setPin(4, 1'b0);
    rd(8'h58, 32'h0000_0010, "R4 edge held after pin returns");
    wr(8'h60, 16'h0010, 16'h0010);
    rd(8'h58, 32'h0, "R6 acknowledge clears edge");
    rd(8'h60, 32'h0, "R6 acknowledge location reads zero");

    // R4 falling on pin 5
    wr(8'h28, 16'h0000, 16'h0020);
    setPin(5, 1'b1);
    rd(8'h58, 32'h0, "R4 falling mode ignores rise");
    setPin(5, 1'b0);
    rd(8'h58, 32'h0000_0020, "R4 falling edge latched");
    wr(8'h60, 16'h0020, 16'h0020);

    // R5 any-edge on pin 20 overrides level-low type/polarity
    wr(8'h34, 16'h0010, 16'h0010);
    wr(8'h24, 16'h0000, 16'h0010);
    wr(8'h2C, 16'h0000, 16'h0010);
    rd(8'h5C, 32'h0, "R5 any-edge suppresses level sense");
    setPin(20, 1'b1);
    rd(8'h5C, 32'h0000_0010, "R5 rise caught");
    wr(8'h64, 16'h0010, 16'h0010);
    rd(8'h5C, 32'h0, "R6 high-half acknowledge");
    setPin(20, 1'b0);
    rd(8'h5C, 32'h0000_0010, "R5 fall caught");
    wr(8'h64, 16'h0010, 16'h0010);

    // R8 mask on pin 4
    wr(8'h18, 16'h0010, 16'h0010);
    setPin(4, 1'b1);
    rd(8'h58, 32'h0000_0010, "R8 raw records masked pin");
    rd(8'h50, 32'h0, "R8 masked status blocked");
    irqChk(1'b0, "R8 irq blocked by mask");
    wr(8'h18, 16'h0000, 16'h0010);
    rd(8'h50, 32'h0000_0010, "R8 unmasked shows status");
    irqChk(1'b1, "R9 irq after unmask");
    wr(8'h60, 16'h0010, 16'h0010);

    // R10 status locations are read-only
    wr(8'h58, 16'hFFFF, 16'hFFFF);
    wr(8'h50, 16'hFFFF, 16'hFFFF);
    wr(8'h5C, 16'hFFFF, 16'hFFFF);
    rd(8'h58, 32'h0, "R10 raw unchanged by write");
    rd(8'h5C, 32'h0, "R10 raw high unchanged by write");
    irqChk(1'b0, "R10 irq unchanged by status write");

    // R7 enable
    wr(8'h10, 16'h0000, 16'h0010);
    setPin(4, 1'b0);
    setPin(4, 1'b1);
    rd(8'h58, 32'h0, "R7 disabled pin records nothing");
    wr(8'h10, 16'h0010, 16'h0010);
    setPin(4, 1'b0);
    setPin(4, 1'b1);
    rd(8'h58, 32'h0000_0010, "R7 re-enabled pin records");
    wr(8'h10, 16'h0000, 16'h0010);
    rd(8'h58, 32'h0, "R7 disable drops latched edge");
    wr(8'h10, 16'h0010, 16'h0010);
    rd(8'h58, 32'h0, "R7 re-enable does not restore edge");

    // R6 acknowledge in the same cycle as a new edge
    setPin(4, 1'b0);
    @(posedge clk); #1 pinIn[4] = 1'b1;
    waitc(5);
    rd(8'h58, 32'h0000_0010, "R6 setup latched");
    setPin(4, 1'b0);
    @(posedge clk); #1 pinIn[4] = 1'b1;      // change before edge 1
    @(posedge clk);                           // edge 1: first stage
    @(posedge clk); #1;                       // edge 2: second stage, edge visible
    regAddr = 8'h60; regWr = 1'b1; regWdata = {16'h0010, 16'h0010};
    @(posedge clk); #1 regWr = 1'b0;         // edge 3: edge and acknowledge together
    rd(8'h58, 32'h0000_0010, "R6 new edge wins over acknowledge");
    wr(8'h60, 16'h0010, 16'h0010);
    rd(8'h58, 32'h0, "R6 later acknowledge clears");

    // random phase, compared every cycle against the model
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      pinIn    = pinIn ^ ($urandom & $urandom & $urandom);
      regWr    = (($urandom % 4) == 0);
      regAddr  = pickAddr(int'($urandom % 16));
      regWdata = $urandom;
    end
    @(posedge clk); #1 regWr = 1'b0;

    // initialization sequence: mask, acknowledge, enable all
    wr(8'h18, 16'hFFFF, 16'hFFFF);
    wr(8'h1C, 16'hFFFF, 16'hFFFF);
    wr(8'h60, 16'hFFFF, 16'hFFFF);
    wr(8'h64, 16'hFFFF, 16'hFFFF);
    wr(8'h10, 16'hFFFF, 16'hFFFF);
    wr(8'h14, 16'hFFFF, 16'hFFFF);
    rd(8'h50, 32'h0, "R8 all masked low half");
    rd(8'h54, 32'h0, "R8 all masked high half");
    irqChk(1'b0, "R9 irq low with all masked");

    waitc(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule